// File: doc/BRIEF.md
# Subtract-and-Swap GCD Engine

This block computes the greatest common divisor of two unsigned operands. It does this by repeatedly subtracting one working register from the other, and it exchanges the two registers whenever the first becomes the smaller one. A small controller steps through four working states: Begin, Swap, Subtract and End. It drives five control lines into a datapath made of two working registers (XR and YR), an operand-select multiplexer, a subtractor and comparators. An Idle state comes before Begin, and the block sits there after reset.

A request is a single-cycle `start` pulse, accepted while the block is idle or finished. The operands `x_in` and `y_in` are sampled in the cycle after the pulse, which is the Begin cycle. Each later cycle performs one swap or one subtraction. When XR reaches zero the block settles in End, raises `done`, and presents the result from YR on `z_out`. The parameter `ENC` selects how the controller state is stored: binary or one-hot. The external behaviour is the same for both.

Top module: `gcd_sub_swap`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block in Idle, with `done` = 0, both working registers cleared to 0 (so `z_out` = 0), and all five control lines at 0.
- R2: A `start` pulse seen in Idle or End moves the block to Begin on the next edge. In Begin, select, load-XR and load-YR are 1, and `x_in`/`y_in` are written into XR/YR. `done` is 0 from Begin onward until End is reached again.
- R3: From Begin, Swap or Subtract, the next state is chosen from the values being written into XR/YR in that cycle. It is End if the new XR is 0, Swap if the new YR is 0 or the new XR is less than the new YR, and Subtract otherwise. Equal values therefore go to Subtract.
- R4: Swap exchanges XR and YR in one clock. Subtract writes XR − YR into XR and leaves YR unchanged.
- R5: At most one of select, swap and subtract is high. Subtract implies load-XR=1 and load-YR=0. Swap and select each imply load-XR=1 and load-YR=1. In Idle and End all five lines are 0.
- R6: End holds until a new `start` arrives. While it holds, `done` stays 1 and `z_out` stays unchanged.
- R7: In End, `z_out` equals gcd(X, Y). For X=20 and Y=12 the result is 4, and `done` is first seen high 8 cycles after the start cycle. YR over the steps reads 12, 12, 8, 8, 4, 4, 4.
- R8: X=0 ends straight from Begin. `done` is seen high 2 cycles after the start cycle, with `z_out` = Y (0 when both operands are 0).
- R9: Y=0 with X>0 takes one Swap and then ends. `done` is seen high 3 cycles after the start cycle, with `z_out` = X.
- R10: A `start` pulse while in Begin, Swap or Subtract is ignored, and so are operand changes outside the Begin cycle.
- R11: With `ENC`=0 (binary: Begin 000, Swap 001, Subtract 010, End 011, Idle 100) and with `ENC`=1 (one-hot: Begin bit 0, Swap bit 1, Subtract bit 2, End bit 3, Idle bit 4), results and timing are identical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a computation |
| x_in | input | W | First operand, sampled in the Begin cycle |
| y_in | input | W | Second operand, sampled in the Begin cycle |
| z_out | output | W | Result (contents of YR), valid while done is high |
| done | output | 1 | High while the block is in End |

## Verification
The bench goes after the step decision on equal operands. A design that compared with strict greater-than would swap equal values forever and never finish. It also tries both zero-operand cases. Deciding on stale register contents in Begin, or missing the zero-YR guard, would give wrong results, or a hang on Y=0 that the latency checks catch. It follows YR cycle by cycle through the 20/12 case, which exposes a subtract that disturbs YR or a swap that loses a value. It also pulses start mid-run and checks the two state encodings against each other, so a controller that restarted on a stray pulse, or an encoding with a mis-decoded line, gives a different result or timing.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

   typedef enum logic [2:0] {
      ST_BEGIN = 3'd0,
      ST_SWAP  = 3'd1,
      ST_SUB   = 3'd2,
      ST_END   = 3'd3,
      ST_IDLE  = 3'd4
   } gcd_state_e;

   localparam int NUM_STATES = 5;

   typedef struct packed {
      logic sel;   // route external operands into the registers
      logic ldx;   // write XR
      logic ldy;   // write YR
      logic sub;   // XR gets XR - YR
      logic swp;   // XR and YR exchange
   } gcd_ctl_t;

   // Decision taken in every working state on the values being written
   function automatic gcd_state_e step_next(input logic x_pos,
                                            input logic x_ge,
                                            input logic y_zero);
      if (!x_pos)
         return ST_END;
      else if (y_zero || !x_ge)
         return ST_SWAP;
      else
         return ST_SUB;
   endfunction

endpackage

// File: rtl/gcd_dpath.sv
module gcd_dpath #(
   parameter int W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [W-1:0]     x_in,
   input  logic [W-1:0]     y_in,
   input  gcd_pkg::gcd_ctl_t ctl,
   output logic [W-1:0]     z_out,
   output logic             x_pos,
   output logic             x_ge,
   output logic             y_zero
);
   logic [W-1:0] xr, yr;
   logic [W-1:0] diff;
   logic [W-1:0] x_nxt, y_nxt;

   assign diff = xr - yr;

   always_comb begin
      if (ctl.sel)      x_nxt = x_in;
      else if (ctl.swp) x_nxt = yr;
      else if (ctl.sub) x_nxt = diff;
      else              x_nxt = xr;

      if (ctl.sel)      y_nxt = y_in;
      else if (ctl.swp) y_nxt = xr;
      else              y_nxt = yr;
   end

   // comparators look at the incoming values, so Begin decides on X and Y
   assign x_pos  = (x_nxt != '0);
   assign x_ge   = (x_nxt >= y_nxt);
   assign y_zero = (y_nxt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         xr <= '0;
         yr <= '0;
      end else begin
         if (ctl.ldx) xr <= x_nxt;
         if (ctl.ldy) yr <= y_nxt;
      end
   end

   assign z_out = yr;

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl #(
   parameter int ENC = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              x_pos,
   input  logic              x_ge,
   input  logic              y_zero,
   output gcd_pkg::gcd_ctl_t ctl,
   output logic              fin
);
   import gcd_pkg::*;

   logic       in_begin, in_swap, in_sub, in_end, in_idle;
   gcd_state_e nxt;

   always_comb begin
      if (in_idle || in_end)
         nxt = start ? ST_BEGIN : (in_idle ? ST_IDLE : ST_END);
      else
         nxt = step_next(x_pos, x_ge, y_zero);
   end

   generate
      if (ENC == 0) begin : g_binary
         gcd_state_e q;

         always_ff @(posedge clk) begin
            if (rst) q <= ST_IDLE;
            else     q <= nxt;
         end

         assign in_begin = (q == ST_BEGIN);
         assign in_swap  = (q == ST_SWAP);
         assign in_sub   = (q == ST_SUB);
         assign in_end   = (q == ST_END);
         assign in_idle  = (q == ST_IDLE);

         // two-bit code decode, upper bit marks Idle
         assign ctl.sel = in_begin;
         assign ctl.swp = in_swap;
         assign ctl.sub = in_sub;
         assign ctl.ldx = !q[2] && !(q[1] && q[0]);
         assign ctl.ldy = !q[2] && !q[1];
      end else begin : g_onehot
         logic [NUM_STATES-1:0] q;

         always_ff @(posedge clk) begin
            if (rst) q <= NUM_STATES'(1) << ST_IDLE;
            else     q <= NUM_STATES'(1) << nxt;
         end

         assign in_begin = q[ST_BEGIN];
         assign in_swap  = q[ST_SWAP];
         assign in_sub   = q[ST_SUB];
         assign in_end   = q[ST_END];
         assign in_idle  = q[ST_IDLE];

         assign ctl.sel = q[0];
         assign ctl.swp = q[1];
         assign ctl.sub = q[2];
         assign ctl.ldx = q[0] | q[1] | q[2];
         assign ctl.ldy = q[0] | q[1];
      end
   endgenerate

   assign fin = in_end;

endmodule

// File: rtl/gcd_sub_swap.sv
module gcd_sub_swap #(
   parameter int W   = 8,
   parameter int ENC = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic [W-1:0] x_in,
   input  logic [W-1:0] y_in,
   output logic [W-1:0] z_out,
   output logic         done
);
   import gcd_pkg::*;

   generate
      if (W < 2) begin : g_bad_width
         $error("gcd_sub_swap: W must be at least 2");
      end
      if (ENC != 0 && ENC != 1) begin : g_bad_enc
         $error("gcd_sub_swap: ENC must be 0 (binary) or 1 (one-hot)");
      end
   endgenerate

   gcd_ctl_t ctl;
   logic     x_pos, x_ge, y_zero;
   logic     ctl_sel, ctl_ldx, ctl_ldy, ctl_sub, ctl_swp;

   gcd_ctrl #(.ENC(ENC)) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .x_pos  (x_pos),
      .x_ge   (x_ge),
      .y_zero (y_zero),
      .ctl    (ctl),
      .fin    (done)
   );

   gcd_dpath #(.W(W)) u_dpath (
      .clk    (clk),
      .rst    (rst),
      .x_in   (x_in),
      .y_in   (y_in),
      .ctl    (ctl),
      .z_out  (z_out),
      .x_pos  (x_pos),
      .x_ge   (x_ge),
      .y_zero (y_zero)
   );

   assign ctl_sel = ctl.sel;
   assign ctl_ldx = ctl.ldx;
   assign ctl_ldy = ctl.ldy;
   assign ctl_sub = ctl.sub;
   assign ctl_swp = ctl.swp;

endmodule

// File: rtl/gcd_sub_swap_chk.sv
module gcd_sub_swap_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         start,
   input logic         done,
   input logic [W-1:0] z_out,
   input logic         ctl_sel,
   input logic         ctl_ldx,
   input logic         ctl_ldy,
   input logic         ctl_sub,
   input logic         ctl_swp
);
   logic busy;
   assign busy = ctl_sel | ctl_sub | ctl_swp;

   // R1: reset leaves Idle with no result flag and no loads
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> !done && !busy && !ctl_ldx && !ctl_ldy);

   // R2: an accepted start is followed by the Begin decode
   a_r2_start_begin: assert property (@(posedge clk) disable iff (rst)
      start && !busy |=> ctl_sel && ctl_ldx && ctl_ldy && !done);

   // R5: control decode consistency
   a_r5_one_action: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl_sel, ctl_sub, ctl_swp}));
   a_r5_sub_loads: assert property (@(posedge clk) disable iff (rst)
      ctl_sub |-> ctl_ldx && !ctl_ldy);
   a_r5_swap_loads: assert property (@(posedge clk) disable iff (rst)
      (ctl_swp || ctl_sel) |-> ctl_ldx && ctl_ldy);
   a_r5_quiet_end: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy && !ctl_ldx && !ctl_ldy);

   // R6: End holds with a stable result until a new start
   a_r6_end_holds: assert property (@(posedge clk) disable iff (rst)
      done && !start |=> done && $stable(z_out));

   // R10: no return to Begin from Begin, Swap or Subtract
   a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
      busy |=> !ctl_sel);

endmodule

bind gcd_sub_swap gcd_sub_swap_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .done    (done),
   .z_out   (z_out),
   .ctl_sel (ctl_sel),
   .ctl_ldx (ctl_ldx),
   .ctl_ldy (ctl_ldy),
   .ctl_sub (ctl_sub),
   .ctl_swp (ctl_swp)
);

// File: tb/tb_gcd_sub_swap.sv
`timescale 1ns/100ps
module tb_gcd_sub_swap;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [W-1:0] x_in = '0;
   logic [W-1:0] y_in = '0;
   logic [W-1:0] z_a, z_b;
   logic         done_a, done_b;

   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];
   logic done_prev = 1'b0;

   always #2.5 clk = ~clk;

   gcd_sub_swap #(.W(W), .ENC(0)) dut (
      .clk(clk), .rst(rst), .start(start), .x_in(x_in), .y_in(y_in),
      .z_out(z_a), .done(done_a));

   gcd_sub_swap #(.W(W), .ENC(1)) dut_oh (
      .clk(clk), .rst(rst), .start(start), .x_in(x_in), .y_in(y_in),
      .z_out(z_b), .done(done_b));

   function automatic void chk(input bit ok, input string req,
                               input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endfunction

   function automatic int ref_gcd(input int a, input int b);
      int t;
      while (b != 0) begin
         t = a % b;
         a = b;
         b = t;
      end
      return a;
   endfunction

   // monitor: pop the scoreboard on each rising done
   always @(negedge clk) begin
      if (!rst) begin
         if (done_a && !done_prev) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 done without request", int'(z_a), -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(int'(z_a) == e, "R7 result", int'(z_a), e);
               chk(int'(z_b) == e && done_b, "R11 one-hot result", int'(z_b), e);
            end
         end
         done_prev = done_a;
      end
   end

   // driver: one request, returns cycles until done seen
   task automatic run_one(input int x, input int y, output int lat);
      @(negedge clk);
      x_in  = W'(x);
      y_in  = W'(y);
      start = 1'b1;
      exp_q.push_back(ref_gcd(x, y));
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done_a && lat < 2000) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      int lat;
      int yr_trace[7] = '{12, 12, 8, 8, 4, 4, 4};
      logic [W-1:0] z_hold;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk(!done_a && !done_b, "R1 done after reset", int'(done_a), 0);
      chk(z_a == '0, "R1 result after reset", int'(z_a), 0);

      // R4/R7: 20,12 with YR traced every step
      @(negedge clk);
      x_in = 8'd20; y_in = 8'd12; start = 1'b1;
      exp_q.push_back(4);
      @(negedge clk);
      start = 1'b0;
      chk(!done_a, "R2 done low in Begin", int'(done_a), 0);
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         chk(int'(z_a) == yr_trace[k], "R4 YR trace", int'(z_a), yr_trace[k]);
         chk(done_a == (k == 6), "R7 done timing", int'(done_a), int'(k == 6));
      end

      // R6: End holds
      z_hold = z_a;
      repeat (4) @(negedge clk);
      chk(done_a && z_a == z_hold, "R6 end hold", int'(z_a), int'(z_hold));

      // R8: X = 0
      run_one(0, 9, lat);
      chk(lat == 2, "R8 zero X latency", lat, 2);
      run_one(0, 0, lat);
      chk(lat == 2 && z_a == '0, "R8 both zero", int'(z_a), 0);

      // R9: Y = 0
      run_one(5, 0, lat);
      chk(lat == 3, "R9 zero Y latency", lat, 3);

      // R3: equal operands subtract, smaller first swaps
      run_one(9, 9, lat);
      chk(lat == 3, "R3 equal operands", lat, 3);
      run_one(3, 5, lat);
      chk(lat == 9, "R3 swap first", lat, 9);

      // R2: restart straight from End drops done next cycle
      @(negedge clk);
      x_in = 8'd14; y_in = 8'd21; start = 1'b1;
      exp_q.push_back(7);
      @(negedge clk);
      start = 1'b0;
      chk(!done_a, "R2 restart from End", int'(done_a), 0);
      // R10: stray start and operand change mid-run are ignored
      @(negedge clk);
      start = 1'b1; x_in = 8'd99; y_in = 8'd3;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done_a && lat < 2000) begin
         @(negedge clk);
         lat++;
      end
      chk(int'(z_a) == 7, "R10 stray start ignored", int'(z_a), 7);

      // R7/R11: sweep of operand pairs
      for (int i = 0; i < 24; i++) begin
         run_one((i * 73 + 29) % 256, (i * 151 + 7) % 256, lat);
      end
      run_one(255, 1, lat);
      run_one(128, 96, lat);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule